// File: doc/BRIEF.md
# DTMF Keypad Tone-Select Logic

This block sits between a telephone-style keypad and a dual-tone generator. It takes four row lines and four column lines, already converted to clean active-high logic, and decides which tones the generator should produce. The outputs are a low-group (row) tone enable, a high-group (column) tone enable, and a 2-bit index for each group. The lines can come from a two-of-eight keypad or from direct electronic drive.

The decision depends on how many lines are active. A single key gives both tones. Extra keys held in one row or one column reduce the output to a single tone. Keys pressed on a diagonal give silence. A column line driven alone gives its own tone, while a row line driven alone gives nothing. A single-tone-inhibit control limits the output to dual tones only.

Two further outputs show whether any line is active: a mute drive and a transmitter-active flag. The inhibit control does not affect either of them. Every input passes through a two-flop synchroniser. The line inputs are then debounced over a programmable number of clock cycles before the decode. All outputs are registered.

Top module: `dtmf_keysel`

## Requirements
- R1: When exactly one row line and exactly one column line are active, both `row_tone_o` and `col_tone_o` are high. `row_sel_o` holds the index of the active row and `col_sel_o` holds the index of the active column, where bit k of a line bus has index k.
- R2: When two or more row lines and exactly one column line are active, only `col_tone_o` is high. `col_sel_o` gives that column.
- R3: When exactly one row line and two or more column lines are active, only `row_tone_o` is high. `row_sel_o` gives that row.
- R4: When two or more row lines and two or more column lines are active, neither tone is enabled.
- R5: When exactly one column line is active and no row line is active, only `col_tone_o` is high. When two or more column lines are active and no row line is active, no tone is enabled.
- R6: When row lines are active and no column line is active, no tone is enabled.
- R7: While `single_inh_i` is high, a tone is enabled only in the case where both tones would be enabled. Every single-tone case gives no tone.
- R8: `mute_o` is high when any row or column line is active and low otherwise, whatever the value of `single_inh_i`.
- R9: `xmit_act_o` is high when any row or column line is active and low otherwise, whatever the value of `single_inh_i`.
- R10: When a tone is not enabled, its index output reads 0.
- R11: A change on the lines that lasts fewer than `DB_CYCLES` clock cycles does not change any output.
- R12: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| row_i | input | 4 | Row lines, active high, bit k is row index k |
| col_i | input | 4 | Column lines, active high, bit k is column index k |
| single_inh_i | input | 1 | High allows dual tones only |
| row_tone_o | output | 1 | Row (low-group) tone enable |
| col_tone_o | output | 1 | Column (high-group) tone enable |
| row_sel_o | output | 2 | Selected row index |
| col_sel_o | output | 2 | Selected column index |
| mute_o | output | 1 | High while any line is active |
| xmit_act_o | output | 1 | High while any line is active |

## Verification
The assertions check on every cycle how the debounced line pattern maps to the registered outputs. They cover the single-key, one-column, diagonal and lone-row cases, the rule that inhibit keeps the two tone enables equal, the activity outputs, zero indices on disabled tones, and the rule that the debounced state changes only to a value that has been held. Only the bench scenarios can show the full path from the pins through the synchroniser and debounce. In particular, the bench shows that a short glitch never reaches the outputs and that each index names the correct key position.

// File: rtl/dtmf_keysel_pkg.sv
package dtmf_keysel_pkg;
  localparam int unsigned N_ROW = 4;
  localparam int unsigned N_COL = 4;
  localparam int unsigned ROW_IDX_W = $clog2(N_ROW);
  localparam int unsigned COL_IDX_W = $clog2(N_COL);
  localparam int unsigned N_LINES = N_ROW + N_COL;

  typedef struct packed {
    logic [N_ROW-1:0] row;
    logic [N_COL-1:0] col;
  } lines_t;
endpackage

// File: rtl/keysel_sync.sv
module keysel_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end
    assign q_o[b] = sync_q;
  end
endmodule

// File: rtl/keysel_debounce.sv
module keysel_debounce #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned DB_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned CNT_W = $clog2(DB_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

  logic [WIDTH-1:0] cand_q, stable_q;
  logic [CNT_W-1:0] cnt_q;

  // restart the count on any change; accept the value once held long enough
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q   <= '0;
      stable_q <= '0;
      cnt_q    <= '0;
    end else if (d_i != cand_q) begin
      cand_q <= d_i;
      cnt_q  <= '0;
    end else if (cnt_q == CNT_LAST) begin
      stable_q <= cand_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = stable_q;

  p_settle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stable_q) |-> (stable_q == $past(cand_q)) && ($past(d_i) == $past(cand_q)));
endmodule

// File: rtl/keysel_decode.sv
module keysel_decode
  import dtmf_keysel_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  lines_t               lines_i,
  input  logic                 inh_i,
  output logic                 row_tone_o,
  output logic                 col_tone_o,
  output logic [ROW_IDX_W-1:0] row_sel_o,
  output logic [COL_IDX_W-1:0] col_sel_o,
  output logic                 mute_o,
  output logic                 xmit_act_o
);
  localparam int unsigned NR_W = $clog2(N_ROW + 1);
  localparam int unsigned NC_W = $clog2(N_COL + 1);

  logic [NR_W-1:0] n_row;
  logic [NC_W-1:0] n_col;
  logic row_ok, col_ok, row_en, col_en, any_act;
  logic [ROW_IDX_W-1:0] row_idx;
  logic [COL_IDX_W-1:0] col_idx;

  always_comb begin
    n_row = '0;
    for (int i = 0; i < N_ROW; i++) n_row = n_row + NR_W'(lines_i.row[i]);
    n_col = '0;
    for (int i = 0; i < N_COL; i++) n_col = n_col + NC_W'(lines_i.col[i]);
  end

  always_comb begin
    row_idx = '0;
    for (int i = 0; i < N_ROW; i++) if (lines_i.row[i]) row_idx = ROW_IDX_W'(i);
    col_idx = '0;
    for (int i = 0; i < N_COL; i++) if (lines_i.col[i]) col_idx = COL_IDX_W'(i);
  end

  // a lone column gives a tone; a lone row needs a column line present
  assign col_ok  = (n_col == NC_W'(1));
  assign row_ok  = (n_row == NR_W'(1)) && (n_col != '0);
  assign col_en  = col_ok && (!inh_i || row_ok);
  assign row_en  = row_ok && (!inh_i || col_ok);
  assign any_act = (|lines_i.row) || (|lines_i.col);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_tone_o <= 1'b0;
      col_tone_o <= 1'b0;
      row_sel_o  <= '0;
      col_sel_o  <= '0;
      mute_o     <= 1'b0;
      xmit_act_o <= 1'b0;
    end else begin
      row_tone_o <= row_en;
      col_tone_o <= col_en;
      row_sel_o  <= row_en ? row_idx : '0;
      col_sel_o  <= col_en ? col_idx : '0;
      mute_o     <= any_act;
      xmit_act_o <= any_act;
    end
  end

  p_single_key_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(lines_i.row) == 1 && $countones(lines_i.col) == 1) |=> row_tone_o && col_tone_o);
  p_col_group_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(lines_i.row) >= 2 && $countones(lines_i.col) == 1 && !inh_i)
      |=> !row_tone_o && col_tone_o);
  p_diag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(lines_i.row) >= 2 && $countones(lines_i.col) >= 2) |=> !row_tone_o && !col_tone_o);
  p_row_alone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lines_i.col == '0) |=> !row_tone_o);
  p_inhibit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_i |=> (row_tone_o == col_tone_o));
  p_mute_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|lines_i.row) || (|lines_i.col)) |=> mute_o && xmit_act_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lines_i.row == '0 && lines_i.col == '0) |=> !mute_o && !xmit_act_o);
  p_idx_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_tone_o |-> row_sel_o == '0) and (!col_tone_o |-> col_sel_o == '0));
endmodule

// File: rtl/dtmf_keysel.sv
module dtmf_keysel
  import dtmf_keysel_pkg::*;
#(
  parameter int unsigned DB_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ROW-1:0] row_i,
  input  logic [N_COL-1:0] col_i,
  input  logic             single_inh_i,
  output logic             row_tone_o,
  output logic             col_tone_o,
  output logic [ROW_IDX_W-1:0] row_sel_o,
  output logic [COL_IDX_W-1:0] col_sel_o,
  output logic             mute_o,
  output logic             xmit_act_o
);
  lines_t raw_lines, sync_lines, db_lines;
  logic   inh_sync;

  assign raw_lines.row = row_i;
  assign raw_lines.col = col_i;

  keysel_sync #(.WIDTH(N_LINES)) u_sync_lines (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (raw_lines), .q_o (sync_lines)
  );

  keysel_sync #(.WIDTH(1)) u_sync_inh (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (single_inh_i), .q_o (inh_sync)
  );

  keysel_debounce #(.WIDTH(N_LINES), .DB_CYCLES(DB_CYCLES)) u_debounce (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sync_lines), .q_o (db_lines)
  );

  keysel_decode u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lines_i    (db_lines),
    .inh_i      (inh_sync),
    .row_tone_o (row_tone_o),
    .col_tone_o (col_tone_o),
    .row_sel_o  (row_sel_o),
    .col_sel_o  (col_sel_o),
    .mute_o     (mute_o),
    .xmit_act_o (xmit_act_o)
  );
endmodule

// File: tb/tb_dtmf_keysel.sv
module tb_dtmf_keysel;
  localparam int unsigned DB = 6;
  localparam int unsigned SETTLE = DB + 12;

  typedef struct {
    logic       rt, ct;
    logic [1:0] rs, cs;
    logic       mu, xa;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] row_i = '0, col_i = '0;
  logic       inh_i = 1'b0;
  logic       row_tone_o, col_tone_o, mute_o, xmit_act_o;
  logic [1:0] row_sel_o, col_sel_o;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dtmf_keysel #(.DB_CYCLES(DB)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .row_i (row_i), .col_i (col_i),
    .single_inh_i (inh_i), .row_tone_o (row_tone_o), .col_tone_o (col_tone_o),
    .row_sel_o (row_sel_o), .col_sel_o (col_sel_o), .mute_o (mute_o),
    .xmit_act_o (xmit_act_o)
  );

  function automatic int ones(logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [1:0] pos(logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic exp_t model(logic [3:0] r, logic [3:0] c, logic inh, string tag);
    exp_t e;
    logic cok, rok;
    cok = (ones(c) == 1);
    rok = (ones(r) == 1) && (ones(c) >= 1);
    e.ct = cok && (!inh || rok);
    e.rt = rok && (!inh || cok);
    e.rs = e.rt ? pos(r) : 2'd0;
    e.cs = e.ct ? pos(c) : 2'd0;
    e.mu = (r != 0) || (c != 0);
    e.xa = e.mu;
    e.tag = tag;
    return e;
  endfunction

  task automatic push(exp_t e);
    @(posedge clk);
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic apply(logic [3:0] r, logic [3:0] c, logic inh, string tag);
    row_i = r; col_i = c; inh_i = inh;
    repeat (SETTLE) @(posedge clk);
    push(model(r, c, inh, tag));
  endtask

  // monitor: compare one queued item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if ({row_tone_o, col_tone_o, row_sel_o, col_sel_o, mute_o, xmit_act_o} !==
            {e.rt, e.ct, e.rs, e.cs, e.mu, e.xa}) begin
          n_bad++;
          $display("FAIL %s: got rt=%b ct=%b rs=%0d cs=%0d mu=%b xa=%b exp rt=%b ct=%b rs=%0d cs=%0d mu=%b xa=%b",
            e.tag, row_tone_o, col_tone_o, row_sel_o, col_sel_o, mute_o, xmit_act_o,
            e.rt, e.ct, e.rs, e.cs, e.mu, e.xa);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    q.push_back(model(4'b0, 4'b0, 1'b0, "R12 reset"));
    @(posedge clk);
    rst_ni = 1'b1;
    apply(4'b0000, 4'b0000, 1'b0, "R8 R9 idle");
    // R1 every key position
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        apply(4'(1 << r), 4'(1 << c), 1'b0, "R1 single key");
    apply(4'b0011, 4'b0100, 1'b0, "R2 two keys one column");
    apply(4'b1111, 4'b0001, 1'b0, "R2 four rows one column");
    apply(4'b0100, 4'b1001, 1'b0, "R3 two keys one row");
    apply(4'b1000, 4'b0111, 1'b0, "R3 three cols one row");
    apply(4'b0101, 4'b0110, 1'b0, "R4 diagonal");
    apply(4'b0000, 4'b0010, 1'b0, "R5 lone column");
    apply(4'b0000, 4'b1100, 1'b0, "R5 two columns no row");
    apply(4'b0010, 4'b0000, 1'b0, "R6 lone row");
    apply(4'b1010, 4'b0000, 1'b0, "R6 rows no column");
    apply(4'b0010, 4'b1000, 1'b1, "R7 inhibit dual");
    apply(4'b0011, 4'b0100, 1'b1, "R7 inhibit column group");
    apply(4'b0100, 4'b1001, 1'b1, "R7 inhibit row group");
    apply(4'b0000, 4'b0010, 1'b1, "R7 R8 R9 inhibit lone column");
    apply(4'b0001, 4'b0000, 1'b1, "R8 R9 inhibit lone row");
    apply(4'b0000, 4'b0000, 1'b1, "R8 R9 inhibit idle");
    apply(4'b1000, 4'b0000, 1'b0, "R10 row without tone");
    // R11: glitch shorter than DB must not reach outputs
    apply(4'b0001, 4'b0001, 1'b0, "R11 base");
    fork
      begin
        col_i = 4'b0011;
        repeat (DB - 2) @(posedge clk);
        col_i = 4'b0001;
      end
      begin
        for (int k = 0; k < 2 * DB + 6; k++) push(model(4'b0001, 4'b0001, 1'b0, "R11 glitch"));
      end
    join
    apply(4'b0001, 4'b0011, 1'b0, "R11 long change accepted");
    repeat (4) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule